// File: doc/BRIEF.md
# Variable-Width Byte Packer with Packet Flush

The packer takes one beat per clock from a wide bus. Each beat holds a variable number of valid bytes, packed from the most significant end downward. The block squeezes out the gaps between beats and emits only completely filled output words, again packed from the top. Bytes left over after a full word are held in a residue register and become the head of the next word.

Packet markers travel with the data. When a beat carries end-of-packet, the residue is flushed as a final word. That word is padded with zeros at the low end and carries a trailing-byte count. The next packet then starts at byte zero of a fresh word. If the last beat overflows the current word, the flush takes two output beats, so the source leaves the cycle after every end-of-packet beat idle.

The byte shift is split over two register stages. The first stage shifts by a multiple of four bytes and the second by the remaining zero to three bytes, which keeps each mux shallow. The bus width is a parameter (16, 32 or 64 bytes).

Top module: `byte_packer`

## Requirements
- R1: Concatenating the valid output bytes of a packet, first word first and top byte first within each word, reproduces exactly the concatenated valid input bytes of that packet.
- R2: The input count `inCnt` (log2 of BYTES bits wide) selects the top bytes of `inData` as valid: a value k from 1 to BYTES-1 marks bytes at bit positions [DW-1 : DW-8k], and 0 marks the whole bus. Bytes below the valid ones never reach the output.
- R3: A word that is not the last of its packet has all BYTES bytes valid and `outCnt` equal to 0.
- R4: The last word of a packet has `outEop` high and `outCnt` equal to its number of valid bytes, with 0 meaning all BYTES. Every byte below the valid ones is zero.
- R5: When the final beat pushes the packet past a word boundary, a full word is emitted, and the tail bytes follow as the end-of-packet word on the very next cycle.
- R6: `outSop` is high only on the first word of each packet and `outEop` only on its last. Both stay low while `outValid` is low.
- R7: A packet of L bytes produces exactly ceil(L/BYTES) output words, and no word mixes bytes of two packets.
- R8: Cycles with `inValid` low produce no output of their own and leave the held residue unchanged.
- R9: A word appears on the outputs two clock edges after the input beat that completes it. A flushed tail word appears one cycle after that.
- R10: Synchronous active-high `rst` clears `outValid` and the residue, and no output appears until new input arrives.
- R11: The cycle after a beat with `inEop` high carries `inValid` low. This cycle is the slot for the tail word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input beat valid |
| inSop | input | 1 | Beat starts a packet |
| inEop | input | 1 | Beat ends a packet |
| inCnt | input | log2(BYTES) | Number of valid top bytes, 0 means all |
| inData | input | BYTES*8 | Input data, valid bytes at the top |
| outValid | output | 1 | Output word valid |
| outSop | output | 1 | First word of a packet |
| outEop | output | 1 | Last word of a packet |
| outCnt | output | log2(BYTES) | Valid bytes in the last word, 0 means all |
| outData | output | BYTES*8 | Packed output word |

## Verification
A wrong residue count shifts every later byte of the packet. The byte comparison then fails at that packet's end-of-packet word, usually within a handful of beats. It also changes the number of words emitted or the trailing count on the last word. A wrong residue data register, or a wrong shift amount in either stage, shows up as wrong bytes in the very next word that uses them, two or three cycles later. A start flag left set, or a lost tail, shows up at once on the marker outputs or as a word missing from the following cycle.

// File: rtl/byte_packer_pkg.sv
package byte_packer_pkg;
  localparam int FINE_W = 2;

  typedef struct packed {
    logic              valid;
    logic              emit;
    logic              tail;
    logic              sop;
    logic              eop;
    logic [FINE_W-1:0] fine;
  } strobe_t;
endpackage

// File: rtl/packer_ctl.sv
module packer_ctl
  import byte_packer_pkg::*;
#(
  parameter int BYTES = 32,
  localparam int CW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          inSop,
  input  logic          inEop,
  input  logic [CW-1:0] inCnt,
  output logic [CW-1:0] coarseOff,
  output strobe_t       strb,
  output logic [CW-1:0] cntA,
  output logic [CW-1:0] tailCnt
);
  logic [CW-1:0] resCnt;
  logic          firstPend;
  logic [CW:0]   nBytes;
  logic [CW:0]   total;
  logic          full;
  logic          over;

  assign nBytes    = (inCnt == '0) ? (CW+1)'(BYTES) : {1'b0, inCnt};
  assign total     = {1'b0, resCnt} + nBytes;
  assign full      = total[CW];
  assign over      = total > (CW+1)'(BYTES);
  assign coarseOff = {resCnt[CW-1:FINE_W], {FINE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      resCnt    <= '0;
      firstPend <= 1'b0;
      strb      <= '0;
      cntA      <= '0;
      tailCnt   <= '0;
    end else if (inValid) begin
      strb.valid <= 1'b1;
      strb.emit  <= full || inEop;
      strb.tail  <= inEop && over;
      strb.sop   <= firstPend || inSop;
      strb.eop   <= inEop && !over;
      strb.fine  <= resCnt[FINE_W-1:0];
      cntA       <= (inEop && !over) ? total[CW-1:0] : '0;
      tailCnt    <= total[CW-1:0];
      resCnt     <= inEop ? '0 : total[CW-1:0];
      if (full || inEop) firstPend <= 1'b0;
      else if (inSop)    firstPend <= 1'b1;
    end else begin
      strb.valid <= 1'b0;
    end
  end
endmodule

// File: rtl/packer_dp.sv
module packer_dp
  import byte_packer_pkg::*;
#(
  parameter int BYTES = 32,
  localparam int DW = BYTES * 8,
  localparam int CW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] inCnt,
  input  logic [DW-1:0] inData,
  input  logic [CW-1:0] coarseOff,
  input  strobe_t       strb,
  input  logic [CW-1:0] cntA,
  input  logic [CW-1:0] tailCnt,
  output logic          outValid,
  output logic          outSop,
  output logic          outEop,
  output logic [CW-1:0] outCnt,
  output logic [DW-1:0] outData
);
  logic [CW:0]     nBytes;
  logic [DW-1:0]   masked;
  logic [2*DW-1:0] aWin;
  logic [2*DW-1:0] shifted;
  logic [2*DW-1:0] merged;
  logic [DW-1:0]   resData;
  logic            tailPend;
  logic [CW-1:0]   tailCntQ;

  assign nBytes = (inCnt == '0) ? (CW+1)'(BYTES) : {1'b0, inCnt};

  for (genvar i = 0; i < BYTES; i++) begin : g_mask
    assign masked[DW-1-8*i -: 8] = ((CW+1)'(i) < nBytes) ? inData[DW-1-8*i -: 8] : 8'h00;
  end

  // stage A: coarse shift by whole groups of four bytes
  always_ff @(posedge clk) begin
    if (rst) aWin <= '0;
    else     aWin <= {masked, {DW{1'b0}}} >> {coarseOff, 3'b000};
  end

  // stage B: fine shift, merge with residue, emit
  assign shifted = aWin >> {strb.fine, 3'b000};
  assign merged  = {resData, {DW{1'b0}}} | shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outCnt   <= '0;
      outData  <= '0;
      resData  <= '0;
      tailPend <= 1'b0;
      tailCntQ <= '0;
    end else if (tailPend) begin
      outValid <= 1'b1;
      outSop   <= 1'b0;
      outEop   <= 1'b1;
      outCnt   <= tailCntQ;
      outData  <= resData;
      resData  <= '0;
      tailPend <= 1'b0;
    end else if (strb.valid && strb.emit) begin
      outValid <= 1'b1;
      outSop   <= strb.sop;
      outEop   <= strb.eop;
      outCnt   <= cntA;
      outData  <= merged[2*DW-1:DW];
      resData  <= strb.eop ? '0 : merged[DW-1:0];
      tailPend <= strb.tail;
      tailCntQ <= tailCnt;
    end else begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outCnt   <= '0;
      if (strb.valid) resData <= merged[2*DW-1:DW];
    end
  end
endmodule

// File: rtl/byte_packer.sv
module byte_packer
  import byte_packer_pkg::*;
#(
  parameter int BYTES = 32,
  localparam int DW = BYTES * 8,
  localparam int CW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          inSop,
  input  logic          inEop,
  input  logic [CW-1:0] inCnt,
  input  logic [DW-1:0] inData,
  output logic          outValid,
  output logic          outSop,
  output logic          outEop,
  output logic [CW-1:0] outCnt,
  output logic [DW-1:0] outData
);
  strobe_t       strb;
  logic [CW-1:0] coarseOff;
  logic [CW-1:0] cntA;
  logic [CW-1:0] tailCnt;

  packer_ctl #(.BYTES(BYTES)) i_ctl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inCnt(inCnt), .coarseOff(coarseOff), .strb(strb), .cntA(cntA), .tailCnt(tailCnt)
  );

  packer_dp #(.BYTES(BYTES)) i_dp (
    .clk(clk), .rst(rst), .inCnt(inCnt), .inData(inData), .coarseOff(coarseOff),
    .strb(strb), .cntA(cntA), .tailCnt(tailCnt), .outValid(outValid), .outSop(outSop),
    .outEop(outEop), .outCnt(outCnt), .outData(outData)
  );
endmodule

// File: rtl/packer_checker.sv
module packer_checker #(
  parameter int BYTES = 32,
  localparam int DW = BYTES * 8,
  localparam int CW = $clog2(BYTES)
) (
  input logic          clk,
  input logic          rst,
  input logic          inValid,
  input logic          inEop,
  input logic          outValid,
  input logic          outSop,
  input logic          outEop,
  input logic [CW-1:0] outCnt,
  input logic [DW-1:0] outData
);
  logic inPkt;

  always_ff @(posedge clk) begin
    if (rst)           inPkt <= 1'b0;
    else if (outValid) inPkt <= !outEop;
  end

  a_r10_reset_quiet: assert property (@(posedge clk) rst |=> !outValid);

  a_r11_gap_after_end: assert property (@(posedge clk) disable iff (rst)
    inValid && inEop |=> !inValid);

  a_r3_full_word_count: assert property (@(posedge clk) disable iff (rst)
    outValid && !outEop |-> outCnt == '0);

  a_r4_zero_pad: assert property (@(posedge clk) disable iff (rst)
    outValid && outEop && outCnt != '0 |-> (outData << {outCnt, 3'b000}) == '0);

  a_r6_sop_first: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outSop == !inPkt);

  a_r6_flags_quiet: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> !outSop && !outEop);

  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 2) || $past(inValid && inEop, 3));
endmodule

bind byte_packer packer_checker #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inEop(inEop), .outValid(outValid),
  .outSop(outSop), .outEop(outEop), .outCnt(outCnt), .outData(outData)
);

// File: tb/test_byte_packer.sv
`timescale 1ns/1ps
module test_byte_packer;
  localparam int BYTES = 32;
  localparam int DW = BYTES * 8;
  localparam int CW = $clog2(BYTES);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [CW-1:0] inCnt = '0;
  logic [DW-1:0] inData = '0;
  logic outValid, outSop, outEop;
  logic [CW-1:0] outCnt;
  logic [DW-1:0] outData;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] nextByte = 8'h01;
  int curLen = 0;
  logic [7:0] expBytes[$];
  int expLens[$];
  logic [7:0] rxBytes[$];
  int words = 0;
  bit openPkt = 0;

  always #2.5 clk = ~clk;

  byte_packer #(.BYTES(BYTES)) i_byte_packer (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inCnt(inCnt), .inData(inData), .outValid(outValid), .outSop(outSop),
    .outEop(outEop), .outCnt(outCnt), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wordsFor(input int len);
    return (len + BYTES - 1) / BYTES;
  endfunction

  task automatic drive(input bit s, input bit e, input int n);
    @(negedge clk);
    inValid = 1'b1; inSop = s; inEop = e; inCnt = CW'(n % BYTES);
    for (int b = 0; b < BYTES; b++) begin
      if (b < n) begin
        inData[DW-1-8*b -: 8] = nextByte;
        expBytes.push_back(nextByte);
        nextByte++;
        curLen++;
      end else begin
        inData[DW-1-8*b -: 8] = 8'($urandom);
      end
    end
    if (e) begin expLens.push_back(curLen); curLen = 0; end
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; inSop = 1'($urandom); inEop = 1'($urandom); inCnt = CW'($urandom);
    for (int b = 0; b < BYTES; b++) inData[DW-1-8*b -: 8] = 8'($urandom);
  endtask

  // scoreboard for R1, R3, R4, R6, R7
  always @(negedge clk) begin
    if (!rst && outValid) begin
      int nb;
      bit same;
      int len;
      nb = outEop ? ((outCnt == '0) ? BYTES : int'(outCnt)) : BYTES;
      check(outSop == !openPkt, "R6 sop on first word", outSop, !openPkt);
      if (!outEop) check(outCnt == '0, "R3 full word count", outCnt, 0);
      else check((outData << (8*nb)) == '0, "R4 zero padding", 0, 0);
      for (int b = 0; b < nb; b++) rxBytes.push_back(outData[DW-1-8*b -: 8]);
      words++;
      openPkt = 1;
      if (outEop) begin
        len = (expLens.size() > 0) ? expLens.pop_front() : -1;
        check(rxBytes.size() == len, "R1 packet length", rxBytes.size(), len);
        same = 1;
        foreach (rxBytes[k]) begin
          if (expBytes.size() == 0) same = 0;
          else if (expBytes.pop_front() != rxBytes[k]) same = 0;
        end
        check(same, "R1 byte order", same, 1);
        check(words == wordsFor(len), "R7 word count", words, wordsFor(len));
        rxBytes.delete();
        words = 0;
        openPkt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(); idle();
    check(outValid == 1'b0, "R10 quiet after reset", outValid, 0);
    idle(); idle(); idle();
    check(outValid == 1'b0, "R8 idle input gives no output", outValid, 0);

    // R2/R9: one full beat, code 0, single-word packet
    drive(1, 1, BYTES);
    idle();
    check(outValid == 1'b0, "R9 not before two edges", outValid, 0);
    idle();
    check(outValid && outSop && outEop && outCnt == '0, "R9 word after two edges", outValid, 1);
    idle();

    // R5: 20 + 20 bytes -> full word then 8-byte tail
    drive(1, 0, 20);
    drive(0, 1, 20);
    idle();
    idle();
    check(outValid && !outEop, "R5 full word first", outEop, 0);
    idle();
    check(outValid && outEop && outCnt == CW'(8), "R5 tail count", outCnt, 8);
    idle();

    // R8: idle cycles mid packet keep residue
    drive(1, 0, 10);
    for (int i = 0; i < 5; i++) begin
      idle();
      check(outValid == 1'b0, "R8 no output while idle", outValid, 0);
    end
    drive(0, 1, 22);
    idle();
    idle();
    check(outValid && outEop && outCnt == '0, "R8 residue kept, exact fill", outCnt, 0);
    idle();

    // R4: short single-byte packet
    drive(1, 1, 1);
    idle(); idle();
    check(outValid && outEop && outCnt == CW'(1), "R4 one byte count", outCnt, 1);
    idle();

    // random packets
    for (int p = 0; p < 300; p++) begin
      int nbeats;
      nbeats = 1 + int'($urandom % 6);
      for (int b = 0; b < nbeats; b++) begin
        if ($urandom % 5 == 0) idle();
        drive(b == 0, b == nbeats - 1, 1 + int'($urandom % BYTES));
      end
      idle();
    end
    repeat (6) idle();
    check(expLens.size() == 0, "R1 all packets delivered", expLens.size(), 0);
    check(expBytes.size() == 0, "R1 no bytes left", expBytes.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule